// File: doc/BRIEF.md
# FDDI Receive Symbol Path

This block sits behind clock recovery on the receive side of an FDDI physical layer. It takes one recovered bit per clock and chooses between the line input and a transmit-side loopback bit. If asked, it undoes NRZI coding. It then finds 5-bit code group boundaries from the start-delimiter pair J-K. Once aligned, it hands the MAC side one 10-bit word per symbol pair. Each word holds two decoded nibbles, a control flag and an optional parity bit.

Next to the data path, the block keeps two pieces of link state. A line-state classifier reports Quiet, Idle or Halt once enough identical symbols arrive in a row. A saturating counter tallies code groups that are neither data nor a known control symbol.

The aligner FSM has two states. HUNT emits nothing and moves to LOCKED when the last ten bits equal J-K. LOCKED emits a symbol every five bits and a pair every ten. A fresh J-K seen in LOCKED restarts the pair count (transition "realign"). The line-state FSM has four states: ACTIVE, QUIET, IDLE and HALT. On each symbol it goes to the state matching that symbol once the run of identical symbols reaches the threshold. Any other symbol, or a shorter run, sends it back to ACTIVE.

Top module: `fddi_rx_symbol_path`

## Requirements
- R1: When `nrzi_en`=1 the bit used is the selected input XOR the previously selected input (reset value 0). When `nrzi_en`=0 the selected input is used as is.
- R2: `loop_en`=1 selects `loop_bit` and `loop_en`=0 selects `line_bit`. The unselected input has no effect on any output.
- R3: Until the first J-K (11000 then 10001, first bit received first) no word is produced and no symbol reaches the line-state or error logic. The J-K pair is itself delivered as a word. After it a word follows every 10 bits. A J-K seen at any bit position restarts pair alignment at that point.
- R4: Data code groups decode to nibbles 0..F as follows: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: Control code groups decode with the control flag set to these nibble values: Q 00000→0, I 11111→1, H 00100→2, J 11000→3, K 10001→4, T 01101→5, R 00111→6, S 11001→7. Every other code is a violation: nibble F, control flag set.
- R6: `word_out` holds bit 9 parity, bit 8 control (OR of both symbols' flags), bits 7:4 the first symbol received and bits 3:0 the second. `word_valid` pulses for one cycle, two clock edges after the last bit of the pair is sampled.
- R7: With `par_en`=1, bit 9 makes the 9 low bits plus parity odd. With `par_en`=0, bit 9 is 0. `par_en` is sampled on the edge that loads the word.
- R8: `line_state` is 1 (Quiet), 2 (Idle) or 3 (Halt) once at least LS_THRESH consecutive Q, I or H symbols have arrived. It is 0 (Active) otherwise. Any other symbol returns it to 0.
- R9: `err_count` rises by one for each violation code group. It saturates at all ones. `err_clr` clears it on the next edge and wins over a simultaneous increment.
- R10: After reset `word_valid`=0, `line_state`=0 and `err_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nrzi_en | input | 1 | Enable NRZI-to-NRZ conversion |
| loop_en | input | 1 | Take bits from the transmit loopback |
| line_bit | input | 1 | Received line bit |
| loop_bit | input | 1 | Loopback bit from the transmitter |
| par_en | input | 1 | Enable odd parity in bit 9 |
| err_clr | input | 1 | Synchronous clear of the error counter |
| word_valid | output | 1 | Word strobe |
| word_out | output | 10 | Parity, control, two nibbles |
| line_state | output | 2 | 0 Active, 1 Quiet, 2 Idle, 3 Halt |
| err_count | output | ERR_W | Saturating violation count |

## Verification
The bench builds the block with LS_THRESH=4 and ERR_W=4. Those values let a few symbols drive every line-state transition, including the drop back to Active. A run of violations reaches counter saturation at 15 within a short stream. With these values the bench sweeps all 32 code groups, both parity settings, NRZI on and off, both sources of the input mux, and realignment from a half-finished pair.

// File: rtl/rxsym_pkg.sv
package rxsym_pkg;

    localparam int SYM_BITS  = 5;
    localparam int PAIR_BITS = 2 * SYM_BITS;
    localparam logic [PAIR_BITS-1:0] JK_PATTERN = 10'b11000_10001;

    typedef enum logic [1:0] {
        LS_ACTIVE = 2'd0,
        LS_QUIET  = 2'd1,
        LS_IDLE   = 2'd2,
        LS_HALT   = 2'd3
    } line_state_e;

    typedef struct packed {
        logic       ctl;
        logic [3:0] val;
    } sym_dec_t;

    function automatic sym_dec_t decode5(input logic [4:0] c);
        sym_dec_t d;
        unique case (c)
            5'b11110: d = '{1'b0, 4'h0};
            5'b01001: d = '{1'b0, 4'h1};
            5'b10100: d = '{1'b0, 4'h2};
            5'b10101: d = '{1'b0, 4'h3};
            5'b01010: d = '{1'b0, 4'h4};
            5'b01011: d = '{1'b0, 4'h5};
            5'b01110: d = '{1'b0, 4'h6};
            5'b01111: d = '{1'b0, 4'h7};
            5'b10010: d = '{1'b0, 4'h8};
            5'b10011: d = '{1'b0, 4'h9};
            5'b10110: d = '{1'b0, 4'hA};
            5'b10111: d = '{1'b0, 4'hB};
            5'b11010: d = '{1'b0, 4'hC};
            5'b11011: d = '{1'b0, 4'hD};
            5'b11100: d = '{1'b0, 4'hE};
            5'b11101: d = '{1'b0, 4'hF};
            5'b00000: d = '{1'b1, 4'h0};
            5'b11111: d = '{1'b1, 4'h1};
            5'b00100: d = '{1'b1, 4'h2};
            5'b11000: d = '{1'b1, 4'h3};
            5'b10001: d = '{1'b1, 4'h4};
            5'b01101: d = '{1'b1, 4'h5};
            5'b00111: d = '{1'b1, 4'h6};
            5'b11001: d = '{1'b1, 4'h7};
            default:  d = '{1'b1, 4'hF};
        endcase
        return d;
    endfunction

    function automatic logic code_bad(input logic [4:0] c);
        sym_dec_t d;
        d = decode5(c);
        return d.ctl && (d.val == 4'hF);
    endfunction

    function automatic line_state_e ls_kind(input logic [4:0] c);
        unique case (c)
            5'b00000: return LS_QUIET;
            5'b11111: return LS_IDLE;
            5'b00100: return LS_HALT;
            default:  return LS_ACTIVE;
        endcase
    endfunction

endpackage

// File: rtl/rxsym_align.sv
module rxsym_align
    import rxsym_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nrzi_en,
    input  logic                 loop_en,
    input  logic                 line_bit,
    input  logic                 loop_bit,
    output logic                 sym_stb,
    output logic [SYM_BITS-1:0]  sym_code,
    output logic                 pair_stb,
    output logic [PAIR_BITS-1:0] pair_code
);

    localparam int CNT_W = $clog2(PAIR_BITS);
    localparam logic [CNT_W-1:0] SYM_LAST  = CNT_W'(SYM_BITS - 1);
    localparam logic [CNT_W-1:0] PAIR_LAST = CNT_W'(PAIR_BITS - 1);

    typedef enum logic {AL_HUNT, AL_LOCKED} al_state_e;

    al_state_e              state, state_nxt;
    logic                   prev_raw;
    logic [PAIR_BITS-1:0]   sh;
    logic [CNT_W-1:0]       pcnt;
    logic                   raw, nrz, jk;
    logic [PAIR_BITS-1:0]   sh_nxt;

    // source mux and optional line decoding
    assign raw    = loop_en ? loop_bit : line_bit;
    assign nrz    = nrzi_en ? (raw ^ prev_raw) : raw;
    assign sh_nxt = {sh[PAIR_BITS-2:0], nrz};
    assign jk     = (sh_nxt == JK_PATTERN);

    always_comb begin
        state_nxt = state;
        unique case (state)
            AL_HUNT:   if (jk) state_nxt = AL_LOCKED;
            AL_LOCKED: state_nxt = AL_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= AL_HUNT;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_raw  <= 1'b0;
            sh        <= '0;
            pcnt      <= '0;
            sym_stb   <= 1'b0;
            sym_code  <= '0;
            pair_stb  <= 1'b0;
            pair_code <= '0;
        end else begin
            prev_raw  <= raw;
            sh        <= sh_nxt;
            sym_code  <= sh_nxt[SYM_BITS-1:0];
            pair_code <= sh_nxt;
            sym_stb   <= jk || ((state == AL_LOCKED) &&
                                ((pcnt == SYM_LAST) || (pcnt == PAIR_LAST)));
            pair_stb  <= jk || ((state == AL_LOCKED) && (pcnt == PAIR_LAST));
            if (jk || (pcnt == PAIR_LAST)) pcnt <= '0;
            else                           pcnt <= pcnt + 1'b1;
        end
    end

    // R3: nothing leaves the aligner while hunting
    a_r3_silent_in_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (state == AL_HUNT && !jk) |=> !pair_stb && !sym_stb);

    // R3: a delimiter is handed on as a pair
    a_r3_jk_delivered: assert property (@(posedge clk) disable iff (!rst_n)
        jk |=> pair_stb && (pair_code == JK_PATTERN));

endmodule

// File: rtl/rxsym_linestate.sv
module rxsym_linestate
    import rxsym_pkg::*;
#(
    parameter int LS_THRESH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sym_stb,
    input  logic [SYM_BITS-1:0] sym_code,
    output line_state_e         line_state
);

    localparam int RUN_W = $clog2(LS_THRESH + 1);
    localparam logic [RUN_W-1:0] TH = RUN_W'(LS_THRESH);

    line_state_e      state, state_nxt, last, last_nxt, kind;
    logic [RUN_W-1:0] run, run_nxt;

    assign kind = ls_kind(sym_code);

    always_comb begin
        run_nxt   = run;
        last_nxt  = last;
        state_nxt = state;
        if (sym_stb) begin
            last_nxt = kind;
            if (kind == LS_ACTIVE)  run_nxt = '0;
            else if (kind != last)  run_nxt = RUN_W'(1);
            else if (run < TH)      run_nxt = run + 1'b1;
            unique case (state)
                LS_ACTIVE, LS_QUIET, LS_IDLE, LS_HALT:
                    state_nxt = (run_nxt == TH) ? kind : LS_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LS_ACTIVE;
            last  <= LS_ACTIVE;
            run   <= '0;
        end else begin
            state <= state_nxt;
            last  <= last_nxt;
            run   <= run_nxt;
        end
    end

    assign line_state = state;

    // R8: a non-Q/I/H symbol forces Active
    a_r8_other_breaks: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_stb && ls_kind(sym_code) == LS_ACTIVE) |=> line_state == LS_ACTIVE);

    // R8: the state only moves when a symbol arrives
    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_stb |=> $stable(line_state));

endmodule

// File: rtl/rxsym_errcnt.sv
module rxsym_errcnt #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [ERR_W-1:0] count
);

    localparam logic [ERR_W-1:0] MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)                      count <= '0;
        else if (clr)                    count <= '0;
        else if (inc && (count != MAX))  count <= count + 1'b1;
    end

    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAX && !clr) |=> count == MAX);

    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count)) || (count == $past(count) + 1'b1));

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);

endmodule

// File: rtl/fddi_rx_symbol_path.sv
module fddi_rx_symbol_path
    import rxsym_pkg::*;
#(
    parameter int LS_THRESH = 16,
    parameter int ERR_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nrzi_en,
    input  logic             loop_en,
    input  logic             line_bit,
    input  logic             loop_bit,
    input  logic             par_en,
    input  logic             err_clr,
    output logic             word_valid,
    output logic [9:0]       word_out,
    output logic [1:0]       line_state,
    output logic [ERR_W-1:0] err_count
);

    logic                 sym_stb, pair_stb;
    logic [SYM_BITS-1:0]  sym_code;
    logic [PAIR_BITS-1:0] pair_code;
    line_state_e          ls;
    sym_dec_t             dec_hi, dec_lo;
    logic                 ctl;
    logic [7:0]           data;

    rxsym_align u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .nrzi_en   (nrzi_en),
        .loop_en   (loop_en),
        .line_bit  (line_bit),
        .loop_bit  (loop_bit),
        .sym_stb   (sym_stb),
        .sym_code  (sym_code),
        .pair_stb  (pair_stb),
        .pair_code (pair_code)
    );

    rxsym_linestate #(.LS_THRESH(LS_THRESH)) u_ls (
        .clk        (clk),
        .rst_n      (rst_n),
        .sym_stb    (sym_stb),
        .sym_code   (sym_code),
        .line_state (ls)
    );

    rxsym_errcnt #(.ERR_W(ERR_W)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (err_clr),
        .inc   (sym_stb && code_bad(sym_code)),
        .count (err_count)
    );

    assign dec_hi = decode5(pair_code[PAIR_BITS-1:SYM_BITS]);
    assign dec_lo = decode5(pair_code[SYM_BITS-1:0]);
    assign ctl    = dec_hi.ctl | dec_lo.ctl;
    assign data   = {dec_hi.val, dec_lo.val};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_out   <= '0;
        end else begin
            word_valid <= pair_stb;
            if (pair_stb)
                word_out <= {par_en ? ~^{ctl, data} : 1'b0, ctl, data};
        end
    end

    assign line_state = ls;

    // R7: odd parity over the whole word when enabled
    a_r7_parity_odd: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && $past(par_en) |-> ^word_out);

    // R7: parity bit held low when disabled
    a_r7_parity_off: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && !$past(par_en) |-> !word_out[9]);

    // R6: one word per pair, never back to back
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

endmodule

// File: tb/fddi_rx_symbol_path_tb_top.sv
`timescale 1ns/1ps
module fddi_rx_symbol_path_tb_top;

    localparam int TH    = 4;
    localparam int EW    = 4;
    localparam int EMAX  = (1 << EW) - 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, nrzi_en = 1'b0, loop_en = 1'b0;
    logic line_bit = 1'b0, loop_bit = 1'b1, par_en = 1'b1, err_clr = 1'b0;
    logic word_valid;
    logic [9:0] word_out;
    logic [1:0] line_state;
    logic [EW-1:0] err_count;

    fddi_rx_symbol_path #(.LS_THRESH(TH), .ERR_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .nrzi_en(nrzi_en), .loop_en(loop_en),
        .line_bit(line_bit), .loop_bit(loop_bit), .par_en(par_en),
        .err_clr(err_clr), .word_valid(word_valid), .word_out(word_out),
        .line_state(line_state), .err_count(err_count)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    string g_tag = "R3";

    localparam logic [4:0] DTAB [16] = '{
        5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
        5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};

    // {bad, ctl, nibble}
    function automatic logic [5:0] tb_dec(input logic [4:0] c);
        for (int i = 0; i < 16; i++) if (c == DTAB[i]) return {2'b00, 4'(i)};
        case (c)
            5'b00000: return 6'b01_0000;
            5'b11111: return 6'b01_0001;
            5'b00100: return 6'b01_0010;
            5'b11000: return 6'b01_0011;
            5'b10001: return 6'b01_0100;
            5'b01101: return 6'b01_0101;
            5'b00111: return 6'b01_0110;
            5'b11001: return 6'b01_0111;
            default:  return 6'b11_1111;
        endcase
    endfunction

    function automatic int tb_kind(input logic [4:0] c);
        case (c)
            5'b00000: return 1;
            5'b11111: return 2;
            5'b00100: return 3;
            default:  return 0;
        endcase
    endfunction

    // reference model state
    logic [9:0] msh = '0;
    bit   m_locked = 0;
    int   m_pcnt = 0, m_run = 0, m_last = 0, m_ls = 0, m_err = 0;
    logic prev_raw = 1'b0;
    bit   g_probe = 1'b1;
    logic [9:0] exp_q[$];
    logic par_smp = 1'b1;

    always @(posedge clk) par_smp <= par_en;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_sym(input logic [4:0] c);
        int k;
        if (tb_dec(c)[5] && m_err < EMAX) m_err++;
        k = tb_kind(c);
        if (k == 0)           m_run = 0;
        else if (k != m_last) m_run = 1;
        else if (m_run < TH)  m_run++;
        m_last = k;
        m_ls = (m_run == TH) ? k : 0;
    endtask

    task automatic push_bit(input logic b);
        logic raw;
        bit sd, pd;
        raw = nrzi_en ? (prev_raw ^ b) : b;
        prev_raw = raw;
        if (loop_en) begin loop_bit = raw; line_bit = ~raw; end
        else         begin line_bit = raw; loop_bit = ~raw; end
        msh = {msh[8:0], b};
        sd = 0; pd = 0;
        if (msh == 10'b11000_10001) begin
            sd = 1; pd = 1; m_locked = 1; m_pcnt = 0;
        end else if (m_locked) begin
            if (m_pcnt == 4) sd = 1;
            if (m_pcnt == 9) begin sd = 1; pd = 1; m_pcnt = 0; end
            else m_pcnt++;
        end
        if (pd) exp_q.push_back(msh);
        if (sd) model_sym(msh[4:0]);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_sym(input logic [4:0] c, input bit do_clr = 0);
        int e_ls, e_err;
        e_ls = m_ls; e_err = m_err;
        for (int i = 0; i < 5; i++) begin
            if (do_clr) begin
                err_clr = (i == 3);
                if (i == 3) m_err = 0;
            end
            push_bit(c[4 - i]);
            if (i == 1 && g_probe) begin
                check(line_state == 2'(e_ls), "R8 line state", line_state, e_ls);
                check(err_count == EW'(e_err), "R9 error count", err_count, e_err);
            end
        end
        err_clr = 1'b0;
    endtask

    // word monitor
    always @(negedge clk) begin
        if (rst_n && !done && word_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R3 unexpected word", word_out, 0);
            end else begin
                logic [9:0] p, w;
                logic [5:0] hi, lo;
                logic c;
                p = exp_q.pop_front();
                hi = tb_dec(p[9:5]); lo = tb_dec(p[4:0]);
                c = hi[4] | lo[4];
                w = {par_smp ? ~^{c, hi[3:0], lo[3:0]} : 1'b0, c, hi[3:0], lo[3:0]};
                check(word_out == w, g_tag, word_out, w);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    localparam logic [4:0] CJ = 5'b11000, CK = 5'b10001;

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        check(word_valid == 0, "R10 word_valid", word_valid, 0);
        check(line_state == 0, "R10 line_state", line_state, 0);
        check(err_count == 0, "R10 err_count", err_count, 0);
        rst_n = 1'b1;

        // R3: hunting, a violation must not count
        g_tag = "R3";
        send_sym(5'b10101); send_sym(5'b00001); send_sym(5'b10101); send_sym(5'b01001);
        check(exp_q.size() == 0 && err_count == 0, "R3 hunt silent", err_count, 0);

        // R4: all data codes after lock
        send_sym(CJ); send_sym(CK);
        g_tag = "R4";
        for (int i = 0; i < 16; i++) send_sym(DTAB[i]);

        // R5 / R7: control codes, violations, parity off
        g_tag = "R5";
        send_sym(5'b11111); send_sym(5'b01101);
        send_sym(5'b00111); send_sym(5'b11001);
        par_en = 1'b0; g_tag = "R7";
        send_sym(5'b00100); send_sym(5'b00001);
        send_sym(DTAB[3]);  send_sym(5'b00010);
        par_en = 1'b1;

        // R8: line state runs
        g_tag = "R8";
        for (int i = 0; i < 3; i++) send_sym(5'b11111);
        send_sym(DTAB[2]);
        for (int i = 0; i < 6; i++) send_sym(5'b00000);
        for (int i = 0; i < 6; i++) send_sym(5'b11111);
        for (int i = 0; i < 6; i++) send_sym(5'b00100);
        send_sym(DTAB[5]); send_sym(DTAB[6]);

        // R9: saturation then clear
        g_tag = "R9";
        for (int i = 0; i < 20; i++) send_sym(5'b00001);
        send_sym(DTAB[1]); send_sym(DTAB[1], 1'b1);
        send_sym(5'b00010); send_sym(DTAB[0]);

        // R6: exhaustive code sweep, both parity settings
        g_tag = "R6"; g_probe = 1'b0;
        for (int pp = 0; pp < 2; pp++) begin
            par_en = pp[0];
            for (int c = 0; c < 32; c++) send_sym(5'(c));
        end
        par_en = 1'b1;
        send_sym(CJ); send_sym(CK);
        send_sym(DTAB[7]); send_sym(DTAB[8]);
        g_probe = 1'b1;

        // R3: realign from half a pair
        g_tag = "R3";
        send_sym(DTAB[9]); send_sym(DTAB[10]); send_sym(DTAB[11]);
        send_sym(CJ); send_sym(CK);
        send_sym(DTAB[12]); send_sym(DTAB[13]);

        // R1: NRZI input
        g_tag = "R1"; nrzi_en = 1'b1;
        send_sym(CJ); send_sym(CK);
        for (int i = 0; i < 8; i++) send_sym(DTAB[15 - i]);
        send_sym(5'b00111); send_sym(5'b00001);

        // R2: loopback source, line input inverted as a distraction
        g_tag = "R2"; loop_en = 1'b1;
        send_sym(CJ); send_sym(CK);
        for (int i = 0; i < 6; i++) send_sym(DTAB[i * 2]);
        nrzi_en = 1'b0;
        send_sym(CJ); send_sym(CK);
        send_sym(DTAB[4]); send_sym(5'b00001);
        send_sym(DTAB[6]); send_sym(DTAB[7]);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 missing words", exp_q.size(), 0);
        finish_run();
    end

endmodule